// File: doc/BRIEF.md
# Delta-Sigma ADC Serial-Output Sequencer

This block is the digital sequencer of a 16-bit delta-sigma converter that offers a read-only 3-wire serial port. It repeats a fixed three-phase loop. First it converts, then it rests with a finished result, then it shifts that result out. There is no command input. The active-low select line and the loop position alone decide when each phase begins and ends. A stub counter stands in for the modulator and decimator. It counts a parameterised number of system clocks, and at the end of that count it captures the word presented on `conv_result`.

A single serial output line does two jobs. While a conversion runs the line reads high. Once a result is waiting it reads low, so a host can hold select low and poll for the line to drop. After select falls again, the line carries the result most significant bit first. Each falling serial-clock edge advances it by one bit. Raising select, after the whole word or part-way through it, ends the read and starts the next conversion. Select and serial clock are brought into the system clock domain through two-flop synchronizers. The output enable is meant to drive a tri-state pad.

Top module: `adc_serial_seq`

## Requirements
- R1: The phase loop only ever steps convert → sleep → data-out → convert, and the block leaves reset in convert.
- R2: A conversion lasts exactly `CONV_CYCLES` system clocks from the cycle it is entered. At its end the value on `conv_result` is captured as the result.
- R3: The result is `WIDTH` (16) bits, sent most significant bit first. After all bits have gone out, further falling serial-clock edges give 0.
- R4: While `cs_n` has been high for two clocks, `sdo_oe` is 0 (pad high impedance).
- R5: While `cs_n` has been low for two clocks, `sdo_oe` is 1.
- R6: In data-out, each falling edge of `sclk` presents the next bit on `sdo`. Outside data-out, `sclk` has no effect on `sdo` or on the stored result.
- R7: `sdo` is 1 throughout a conversion (busy status).
- R8: `sdo` is 0 in sleep (result ready), including when `cs_n` was already low as the conversion finished.
- R9: A falling `cs_n` in sleep enters data-out and places the MSB on `sdo` before any `sclk` edge. A falling `cs_n` during a conversion is ignored.
- R10: A rising `cs_n` in data-out, after a full or a partial word, starts a new conversion.
- R11: Synchronizer latency is fixed: counted from the first clock edge after `cs_n` rises in data-out, `sdo` reads 0 again after exactly `CONV_CYCLES + 3` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| conv_result | input | WIDTH | Result word from the modulator stub, captured at end of conversion |
| sdo | output | 1 | Serial data / conversion status |
| sdo_oe | output | 1 | Output enable for the tri-state pad |

## Verification
The bench reads 24 result words. These are walking-one patterns, which separate every bit position and catch ordering or off-by-one shifting, plus all-zeros, all-ones, alternating words and a few arithmetic scrambles, which catch stuck or inverted data. Reads alternate between full words and partial words of varying length, to tell a clean restart after an early select release apart from one that leaks old shift state. Each restart is timed to the clock against the conversion length. A last sequence drops select and toggles the serial clock during a conversion, then holds select low through the end of the conversion. This shows that early select and clock activity is ignored and that only a fresh select edge starts the data phase.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 2075000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [WIDTH-1:0] conv_result,
  output logic             sdo,
  output logic             sdo_oe
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  typedef enum logic [1:0] {ST_CONV = 2'd0, ST_SLEEP = 2'd1, ST_DOUT = 2'd2} state_t;

  state_t           state;
  logic [1:0]       cs_sync, sclk_sync;
  logic             cs_q, sclk_q;
  logic [CW-1:0]    conv_cnt;
  logic [WIDTH-1:0] shreg;

  wire cs_s      = cs_sync[1];
  wire cs_fall   = cs_q & ~cs_s;
  wire cs_rise   = ~cs_q & cs_s;
  wire sclk_fall = sclk_q & ~sclk_sync[1];
  wire conv_done = (state == ST_CONV) && (conv_cnt == CW'(CONV_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= 2'b11;
      cs_q      <= 1'b1;
      sclk_sync <= 2'b00;
      sclk_q    <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[0], cs_n};
      cs_q      <= cs_s;
      sclk_sync <= {sclk_sync[0], sclk};
      sclk_q    <= sclk_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      conv_cnt <= '0;
    else if (state != ST_CONV || conv_done)
      conv_cnt <= '0;
    else
      conv_cnt <= conv_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CONV;
      shreg <= '0;
    end else begin
      case (state)
        ST_CONV: if (conv_done) begin
          shreg <= conv_result;
          state <= ST_SLEEP;
        end
        ST_SLEEP: if (cs_fall) state <= ST_DOUT;
        ST_DOUT: begin
          if (cs_rise)        state <= ST_CONV;
          else if (sclk_fall) shreg <= {shreg[WIDTH-2:0], 1'b0};
        end
        default: state <= ST_CONV;
      endcase
    end
  end

  assign sdo    = (state == ST_CONV) ? 1'b1 :
                  (state == ST_DOUT) ? shreg[WIDTH-1] : 1'b0;
  assign sdo_oe = ~cs_s;

endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int CONV_CYCLES = 2075000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [1:0] state,
  input logic       sclk_fall
);

  int conv_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conv_len <= 0;
    else        conv_len <= (state == 2'd0) ? conv_len + 1 : 0;
  end

  AST_CYCLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |->
      ((($past(state) == 2'd0) && (state == 2'd1)) ||
       (($past(state) == 2'd1) && (state == 2'd2)) ||
       (($past(state) == 2'd2) && (state == 2'd0)))); // R1

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(state) == 2'd0) && (state != 2'd0)) |-> (conv_len == CONV_CYCLES)); // R2

  AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe); // R4

  AST_DRIVEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && $past(rst_n, 2)) |-> sdo_oe); // R5

  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 2'd2) && ($past(state) == 2'd2) && (sdo != $past(sdo))) |-> $past(sclk_fall)); // R6

  AST_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> sdo); // R7

  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1) |-> !sdo); // R8

endmodule

bind adc_serial_seq adc_serial_seq_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .state(state), .sclk_fall(sclk_fall)
);

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;
  localparam int W = 16;
  localparam int N = 40;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
  logic [W-1:0] conv_result = '0;
  logic sdo, sdo_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_seq #(.WIDTH(W), .CONV_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .conv_result(conv_result), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    if (i < 16)       return 16'(1 << i);
    else if (i == 16) return 16'h0000;
    else if (i == 17) return 16'hFFFF;
    else if (i == 18) return 16'hA5A5;
    else if (i == 19) return 16'h5A5A;
    else              return 16'((i * 40503 + 12345) ^ (i << 9));
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; clocks(3);
    sclk = 1'b0; clocks(4);
  endtask

  task automatic read_word(input logic [W-1:0] p, input int nbits);
    cs_n = 1'b0; clocks(4);
    check(sdo_oe == 1'b1, "R5", sdo_oe, 1);
    check(sdo == p[W-1], "R9", sdo, p[W-1]);
    for (int b = 1; b < nbits; b++) begin
      pulse_sclk();
      check(sdo == p[W-1-b], "R6", sdo, p[W-1-b]);
    end
    if (nbits == W) begin
      pulse_sclk();
      check(sdo == 1'b0, "R3", sdo, 0);
    end
  endtask

  task automatic restart_and_time();
    int edges = 0;
    cs_n = 1'b1;
    while (edges < 500) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (edges == 3) begin
        check(sdo == 1'b1, "R7", sdo, 1);
        check(sdo_oe == 1'b0, "R4", sdo_oe, 0);
      end
      if (edges >= 3 && sdo == 1'b0) break;
    end
    check(edges == N + 3, "R2 R10 R11", edges, N + 3);
    check(sdo == 1'b0, "R8", sdo, 0);
  endtask

  initial begin
    conv_result = pat(0);
    clocks(5);
    check(sdo_oe == 1'b0, "R4", sdo_oe, 0);
    check(sdo == 1'b1, "R1 R7", sdo, 1);
    rst_n = 1'b1;
    clocks(N + 5);
    check(sdo == 1'b0, "R8", sdo, 0);

    for (int i = 0; i < 24; i++) begin
      int nb = (i % 2 == 0) ? W : (i % 15) + 1;
      read_word(pat(i), nb);
      conv_result = pat(i + 1);
      restart_and_time();
    end

    read_word(pat(24), 5);
    conv_result = 16'h3C96;
    cs_n = 1'b1; clocks(6);
    cs_n = 1'b0; clocks(4);
    check(sdo == 1'b1, "R9", sdo, 1);
    check(sdo_oe == 1'b1, "R5", sdo_oe, 1);
    pulse_sclk(); pulse_sclk(); pulse_sclk();
    check(sdo == 1'b1, "R6", sdo, 1);
    clocks(N + 5);
    check(sdo == 1'b0, "R8", sdo, 0);
    pulse_sclk();
    check(sdo == 1'b0, "R9", sdo, 0);
    cs_n = 1'b1; clocks(4);
    read_word(16'h3C96, W);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule